// File: doc/BRIEF.md
# Full-Bridge Gate Control Sequencer

This block turns a single direction command into the four gate-enable signals of an N-channel full bridge. The bridge has two legs, A and B, and each leg has a low-side and a high-side switch. In normal operation one diagonal of the bridge conducts. When the direction bit is 1, A-high and B-low are on. When it is 0, A-low and B-high are on.

A high-side enable input selects chop mode. When it is low, both upper switches stay off and the load current freewheels through the bottom pair. A disable input and an undervoltage flag shut every gate at once. The undervoltage flag arrives already synchronized, with its hysteresis applied outside the block, and it acts exactly like disable.

Every output turns off on the first clock edge after its target drops. Turn-on waits a programmable number of cycles, set separately for the upper and lower switches. This delay is the dead time that keeps a leg from conducting straight through.

Whenever a shutdown clears, and also on leaving reset, a restart sequence runs in two parts. First both low sides are driven on together to recharge the bootstrap capacitors. Then the high sides are held off until a longer hold-off window has run. The direction input passes through a minimum-width filter, so short glitches do not propagate.

The block has no data stream. All of its pins are plain control and status levels, so it has no valid/ready handshake.

Top module: `bridge_gate_seq`

## Requirements
- R1: In steady running with direction 1 and high-side enable 1, the outputs settle to A-low 0, A-high 1, B-low 1, B-high 0.
- R2: In steady running with direction 0 and high-side enable 1, the outputs settle to A-low 1, A-high 0, B-low 0, B-high 1.
- R3: With high-side enable 0, both high-side outputs go low on the next edge, and the low-side outputs keep following the direction (low of leg A when direction is 0, low of leg B when direction is 1).
- R4: While disable or undervoltage is 1, all four outputs are 0 in the same cycle, whatever the other inputs are. All turn-on timers are cleared at the next edge.
- R5: An output whose target drops clears on the next clock edge, with no programmed delay. Within a leg, the low and high outputs are never 1 in the same cycle.
- R6: A high-side output rises on the (HI_DLY+1)-th consecutive edge at which its target is 1. A low-side output rises on the (LO_DLY+1)-th such edge. If the target drops earlier, the pending turn-on is cancelled and the count starts again from zero. A delay of 0 is legal.
- R7: The first edge with both disable and undervoltage at 0 counts as edge 1 of a restart. For REFRESH_CYC cycles after it, both low-side targets are 1 and both high-side targets are 0. The low outputs therefore rise together at edge LO_DLY+2.
- R8: After a restart begins, the high-side targets stay 0 until edge HOLDOFF_CYC+1, so the earliest high-side rise is at edge HOLDOFF_CYC+HI_DLY+2. Leaving reset starts the same sequence, and all outputs are 0 during reset.
- R9: A new direction value takes effect only after it has been present at MIN_PULSE consecutive edges. A shorter pulse has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_i | input | 1 | Direction command (1: A-high/B-low diagonal, 0: A-low/B-high) |
| hi_en_i | input | 1 | High-side enable; 0 selects chop mode |
| dis_i | input | 1 | Disable; 1 forces all gates off |
| uv_i | input | 1 | Synchronized undervoltage flag, treated like disable |
| a_lo_o | output | 1 | Leg A low-side gate enable |
| a_hi_o | output | 1 | Leg A high-side gate enable |
| b_lo_o | output | 1 | Leg B low-side gate enable |
| b_hi_o | output | 1 | Leg B high-side gate enable |

## Verification
The embedded properties watch four things on every cycle:
- No leg has both of its switches on.
- Nothing is on while disable or undervoltage is high, and every timer is clear one edge after a shutdown.
- No high side is on before the restart sequence has reached normal running.
- Each gate turn-off follows a dropped target, and each accepted direction equals the input value.

The exact cycle counts can only be shown by the bench scenarios. These cover the refresh width and hold-off after reset and after shutdowns, the separate dead times, cancellation of a pending turn-on, rejection of short direction glitches, and the full mapping over random mixes of direction, chop and faults.

// File: rtl/bgs_pkg.sv
package bgs_pkg;

  // Restart sequencer phases
  typedef enum logic [1:0] {
    PH_FAULT   = 2'd0,
    PH_REFRESH = 2'd1,
    PH_HOLD    = 2'd2,
    PH_RUN     = 2'd3
  } phase_e;

  // Gate vector bit positions
  localparam int unsigned G_ALO = 0;
  localparam int unsigned G_AHI = 1;
  localparam int unsigned G_BLO = 2;
  localparam int unsigned G_BHI = 3;
  localparam int unsigned NGATE = 4;

  // Target gate pattern for a phase, filtered direction and high-side enable
  function automatic logic [NGATE-1:0] bridge_targets(phase_e ph, logic dir, logic hen);
    logic [NGATE-1:0] t;
    t = '0;
    unique case (ph)
      PH_FAULT:   t = '0;
      PH_REFRESH: begin
        t[G_ALO] = 1'b1;
        t[G_BLO] = 1'b1;
      end
      PH_HOLD: begin
        t[G_ALO] = ~dir;
        t[G_BLO] = dir;
      end
      PH_RUN: begin
        t[G_ALO] = ~dir;
        t[G_BLO] = dir;
        t[G_AHI] = dir & hen;
        t[G_BHI] = ~dir & hen;
      end
      default: t = '0;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/bgs_dir_filter.sv
module bgs_dir_filter #(
  parameter int MIN_PULSE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_i,
  output logic dir_o
);
  localparam int CW = $clog2(MIN_PULSE + 1);

  logic          dir_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      run_q <= '0;
    end else if (dir_i != dir_q) begin
      if (run_q == CW'(MIN_PULSE - 1)) begin
        dir_q <= dir_i;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end

  assign dir_o = dir_q;

  // R9: an accepted direction always equals the value seen at the input
  p_dir_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q != $past(dir_q)) |-> (dir_q == $past(dir_i)));

endmodule

// File: rtl/bgs_restart_seq.sv
module bgs_restart_seq import bgs_pkg::*; #(
  parameter int REFRESH_CYC = 19,
  parameter int HOLDOFF_CYC = 32
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   kill_i,
  output phase_e phase_o
);
  localparam int CW = $clog2(HOLDOFF_CYC + 1);

  phase_e        ph_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_FAULT;
      cnt_q <= '0;
    end else if (kill_i) begin
      ph_q  <= PH_FAULT;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_FAULT: begin
          ph_q  <= PH_REFRESH;
          cnt_q <= '0;
        end
        PH_REFRESH: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(REFRESH_CYC - 1)) ph_q <= PH_HOLD;
        end
        PH_HOLD: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(HOLDOFF_CYC - 1)) ph_q <= PH_RUN;
        end
        default: cnt_q <= '0;
      endcase
    end
  end

  assign phase_o = ph_q;

  // R4: a shutdown always lands the sequencer in the fault phase
  p_kill_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i |=> (ph_q == PH_FAULT));

  // R8: running is only reached through the hold phase
  p_run_via_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_q == PH_RUN) |-> ($past(ph_q) == PH_HOLD));

endmodule

// File: rtl/bgs_onset_timer.sv
module bgs_onset_timer #(
  parameter int DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kill_i,
  input  logic target_i,
  output logic gate_o
);
  localparam int CW = $clog2(DLY + 2);

  logic          gate_q;
  logic [CW-1:0] wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      wait_q <= '0;
    end else if (kill_i || !target_i) begin
      gate_q <= 1'b0;
      wait_q <= '0;
    end else if (!gate_q) begin
      if (wait_q == CW'(DLY)) gate_q <= 1'b1;
      else                    wait_q <= wait_q + 1'b1;
    end
  end

  assign gate_o = gate_q;

  // R5: a dropped target clears the gate on the next edge
  p_fast_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !target_i |=> !gate_q);

  // R6: a gate only rises after its target was present
  p_rise_needs_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |-> $past(target_i));

endmodule

// File: rtl/bridge_gate_seq.sv
module bridge_gate_seq import bgs_pkg::*; #(
  parameter int HI_DLY      = 4,
  parameter int LO_DLY      = 2,
  parameter int REFRESH_CYC = 19,
  parameter int HOLDOFF_CYC = 32,
  parameter int MIN_PULSE   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_i,
  input  logic hi_en_i,
  input  logic dis_i,
  input  logic uv_i,
  output logic a_lo_o,
  output logic a_hi_o,
  output logic b_lo_o,
  output logic b_hi_o
);

  logic             kill;
  logic             dir_f;
  phase_e           phase;
  logic [NGATE-1:0] target;
  logic [NGATE-1:0] gate;

  assign kill = dis_i | uv_i;

  bgs_dir_filter #(.MIN_PULSE(MIN_PULSE)) u_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .dir_i (dir_i),
    .dir_o (dir_f)
  );

  bgs_restart_seq #(.REFRESH_CYC(REFRESH_CYC), .HOLDOFF_CYC(HOLDOFF_CYC)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .kill_i  (kill),
    .phase_o (phase)
  );

  assign target = bridge_targets(phase, dir_f, hi_en_i);

  // Odd positions are high sides, even positions low sides
  for (genvar g = 0; g < NGATE; g++) begin : g_gate
    localparam int GDLY = (g % 2 == 1) ? HI_DLY : LO_DLY;
    bgs_onset_timer #(.DLY(GDLY)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .kill_i   (kill),
      .target_i (target[g]),
      .gate_o   (gate[g])
    );
  end

  assign a_lo_o = gate[G_ALO] & ~kill;
  assign a_hi_o = gate[G_AHI] & ~kill;
  assign b_lo_o = gate[G_BLO] & ~kill;
  assign b_hi_o = gate[G_BHI] & ~kill;

  // R5: no shoot-through in either leg, including restart
  p_leg_a_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_lo_o && a_hi_o));
  p_leg_b_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(b_lo_o && b_hi_o));

  // R4: every timer is cleared one edge after a shutdown request
  p_kill_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (gate == '0));

  // R8: high sides stay dark until the sequencer is running
  p_hi_holdoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_RUN) |-> (!a_hi_o && !b_hi_o));

endmodule

// File: tb/bridge_gate_seq_tb_top.sv
module bridge_gate_seq_tb_top;
  localparam int CLK_PERIOD = 20;
  localparam int HI_DLY = 4;
  localparam int LO_DLY = 2;
  localparam int REFRESH_CYC = 19;
  localparam int HOLDOFF_CYC = 32;
  localparam int MIN_PULSE = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_i = 1'b1, hi_en_i = 1'b1, dis_i = 1'b0, uv_i = 1'b0;
  logic a_lo_o, a_hi_o, b_lo_o, b_hi_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_gate_seq #(.HI_DLY(HI_DLY), .LO_DLY(LO_DLY), .REFRESH_CYC(REFRESH_CYC),
                    .HOLDOFF_CYC(HOLDOFF_CYC), .MIN_PULSE(MIN_PULSE)) dut_i (
    .clk(clk), .rst_n(rst_n), .dir_i(dir_i), .hi_en_i(hi_en_i), .dis_i(dis_i), .uv_i(uv_i),
    .a_lo_o(a_lo_o), .a_hi_o(a_hi_o), .b_lo_o(b_lo_o), .b_hi_o(b_hi_o));

  // Reference model built from the requirement text
  // m_stage: 0 shut, 1 refresh, 2 hold, 3 running
  int         m_stage, m_since, m_seen;
  int         m_wait [4];
  logic       m_dir;
  logic [3:0] m_on;

  function automatic logic [3:0] want(int stage, logic d, logic hen);
    // bit order {b_hi, b_lo, a_hi, a_lo}
    if (stage == 0) return 4'b0000;
    if (stage == 1) return 4'b0101;
    if (stage == 2) return d ? 4'b0100 : 4'b0001;
    if (d) return {1'b0, 1'b1, hen, 1'b0};
    return {hen, 1'b0, 1'b0, 1'b1};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stage <= 0; m_since <= 0; m_seen <= 0; m_dir <= 1'b0; m_on <= '0;
      for (int i = 0; i < 4; i++) m_wait[i] <= 0;
    end else begin : mstep
      logic [3:0] w;
      logic       off;
      off = dis_i | uv_i;
      w = want(m_stage, m_dir, hi_en_i);
      if (dir_i == m_dir) m_seen <= 0;
      else if (m_seen + 1 >= MIN_PULSE) begin m_dir <= dir_i; m_seen <= 0; end
      else m_seen <= m_seen + 1;
      if (off) begin m_stage <= 0; m_since <= 0; end
      else if (m_stage == 0) begin m_stage <= 1; m_since <= 0; end
      else if (m_stage != 3) begin
        m_since <= m_since + 1;
        if (m_stage == 1 && m_since + 1 == REFRESH_CYC) m_stage <= 2;
        if (m_stage == 2 && m_since + 1 == HOLDOFF_CYC) m_stage <= 3;
      end
      for (int i = 0; i < 4; i++) begin
        if (off || !w[i]) begin m_on[i] <= 1'b0; m_wait[i] <= 0; end
        else if (!m_on[i]) begin
          if (m_wait[i] == ((i % 2 == 1) ? HI_DLY : LO_DLY)) m_on[i] <= 1'b1;
          else m_wait[i] <= m_wait[i] + 1;
        end
      end
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_cmp();
    logic [3:0] e;
    string r;
    e = (dis_i | uv_i) ? 4'b0000 : m_on;
    if (dis_i | uv_i) r = "R4";
    else if (m_stage == 1) r = "R7";
    else if (m_stage == 2 || m_stage == 0) r = "R8";
    else if (!hi_en_i) r = "R3";
    else r = m_dir ? "R1" : "R2";
    chk(r, "gates {bh,bl,ah,al}", {b_hi_o, b_lo_o, a_hi_o, a_lo_o} == e, 1'b1);
    if ({b_hi_o, b_lo_o, a_hi_o, a_lo_o} != e)
      $display("  detail: actual %b expected %b", {b_hi_o, b_lo_o, a_hi_o, a_lo_o}, e);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    int hold;
    logic seen;
    seed = 32'd7;
    void'($urandom(seed));
    step(3);
    chk("R8", "reset a_lo", a_lo_o, 1'b0);
    chk("R8", "reset b_lo", b_lo_o, 1'b0);
    chk("R8", "reset a_hi", a_hi_o, 1'b0);
    rst_n = 1'b1;
    // restart from reset with dir=1, hen=1
    step(LO_DLY + 1);
    chk("R6", "a_lo before low delay", a_lo_o, 1'b0);
    step(1);
    chk("R7", "a_lo refresh", a_lo_o, 1'b1);
    chk("R7", "b_lo refresh", b_lo_o, 1'b1);
    step(REFRESH_CYC + 1 - (LO_DLY + 2));
    chk("R7", "a_lo refresh end", a_lo_o, 1'b1);
    step(1);
    chk("R7", "a_lo after refresh", a_lo_o, 1'b0);
    chk("R1", "b_lo after refresh", b_lo_o, 1'b1);
    step(HOLDOFF_CYC + HI_DLY + 1 - (REFRESH_CYC + 2));
    chk("R8", "a_hi during holdoff", a_hi_o, 1'b0);
    step(1);
    chk("R1", "a_hi running", a_hi_o, 1'b1);
    chk("R1", "b_hi running", b_hi_o, 1'b0);
    step(5);
    // direction flip: dir 1 -> 0
    dir_i = 1'b0;
    step(MIN_PULSE);
    chk("R9", "a_hi before accept", a_hi_o, 1'b1);
    step(1);
    chk("R5", "a_hi fast off", a_hi_o, 1'b0);
    chk("R5", "b_lo fast off", b_lo_o, 1'b0);
    step(LO_DLY - 1);
    chk("R6", "a_lo still waiting", a_lo_o, 1'b0);
    step(1);
    chk("R6", "a_lo after low delay", a_lo_o, 1'b1);
    step(HI_DLY - LO_DLY - 1);
    chk("R6", "b_hi still waiting", b_hi_o, 1'b0);
    step(1);
    chk("R2", "b_hi after high delay", b_hi_o, 1'b1);
    step(4);
    // short glitch on direction
    dir_i = 1'b1; step(MIN_PULSE - 1); dir_i = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 10; k++) begin step(1); seen |= a_hi_o | ~a_lo_o | ~b_hi_o; end
    chk("R9", "glitch disturbed outputs", seen, 1'b0);
    // accepted flip reverted before high delay: pending turn-on cancelled
    dir_i = 1'b1; step(MIN_PULSE); dir_i = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 12; k++) begin step(1); seen |= a_hi_o; end
    chk("R6", "cancelled a_hi turn-on", seen, 1'b0);
    chk("R2", "a_lo restored", a_lo_o, 1'b1);
    chk("R2", "b_hi restored", b_hi_o, 1'b1);
    // chop mode
    hi_en_i = 1'b0;
    step(1);
    chk("R3", "b_hi chop", b_hi_o, 1'b0);
    chk("R3", "a_lo chop", a_lo_o, 1'b1);
    hi_en_i = 1'b1;
    step(8);
    // immediate shutdown by disable and by undervoltage
    dis_i = 1'b1; #1;
    chk("R4", "a_lo on disable", a_lo_o, 1'b0);
    chk("R4", "b_hi on disable", b_hi_o, 1'b0);
    step(3); dis_i = 1'b0;
    step(HOLDOFF_CYC + HI_DLY + 6);
    chk("R2", "b_hi back after restart", b_hi_o, 1'b1);
    uv_i = 1'b1; #1;
    chk("R4", "b_hi on undervoltage", b_hi_o, 1'b0);
    chk("R4", "a_lo on undervoltage", a_lo_o, 1'b0);
    step(2); uv_i = 1'b0;
    // random mix against the model
    hold = 0;
    for (int c = 0; c < 4000; c++) begin
      step(1);
      model_cmp();
      if (hold == 0) begin
        dir_i = $urandom_range(0, 1);
        hold  = $urandom_range(1, 12);
      end else hold--;
      if ($urandom_range(0, 40) == 0) hi_en_i = ~hi_en_i;
      if (dis_i) dis_i = ($urandom_range(0, 2) != 0);
      else dis_i = ($urandom_range(0, 220) == 0);
      if (uv_i) uv_i = ($urandom_range(0, 3) != 0);
      else uv_i = ($urandom_range(0, 350) == 0);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule